// File: doc/BRIEF.md
# Serial Controller Interrupt and Event Status Unit

This unit collects the event sources of a queue-based serial controller and presents them to software through a small register window. One-shot events (receive underflow, receive overflow, transmit overflow, transmit abort, start seen, stop seen) are held in sticky bits. The transmit-low and receive-high conditions are computed every cycle from the queue occupancy inputs and the two programmable thresholds. A mask register selects which status bits drive the interrupt line.

Software clears sticky events by reading dedicated clear addresses, not by writing ones. Each clearable event has its own clear address, and one further address clears all of them together. Each clear read returns 1 when the event it clears was set. A transmit abort also records the abort reasons in a cause register and holds the transmit queue flushed until the abort is cleared. Threshold writes saturate at the queue depth minus one, so software can find the queue depth by writing an oversized value and reading it back.

Top module: `intr_status_unit`

## Requirements
- R1: After reset the sticky events, mask, both thresholds and the cause register read 0, and irq is 0 while the status outputs are clear.
- R2: The status word at address 0 always shows every event, whatever the mask. Its bit positions are: 0 receive underflow, 1 receive overflow, 2 receive-high, 3 transmit overflow, 4 transmit-low, 5 transmit abort, 6 start seen, 7 stop seen. A pulse on a sticky event input sets its bit from the next cycle until that bit is cleared.
- R3: The masked status at address 2 equals status AND mask, where the mask is at address 1. irq is 1 exactly when the masked status is nonzero.
- R4: A read of address 9 (receive underflow), 10 (receive overflow), 11 (transmit overflow) or 12 (transmit abort) clears only that sticky bit. The read returns 1 if the bit was set and 0 otherwise.
- R5: A read of address 8 clears all six sticky bits and the cause register. It returns 1 if any sticky bit was set.
- R6: When an event pulse arrives in the same cycle as a read that clears it, the event stays set.
- R7: Each abort pulse ORs the 8-bit abortCause input into the cause register at address 7. The cause bits are: 0 user abort, 1 lost arbitration, 2 address NACK, 3 data NACK, 4 general-call NACK, 5 general-call read, 6 restart-disabled violation, 7 acknowledged START byte. txFlush is 1 while the abort bit is set. Clearing the abort (address 12 or 8) zeroes the cause register and releases txFlush.
- R8: A write to the transmit threshold (address 3) or receive threshold (address 4) stores the written value, or DEPTH-1 if the value is larger.
- R9: Status bit 4 is 1 while txLevel <= transmit threshold. Status bit 2 is 1 while rxLevel > receive threshold. Neither bit is sticky.
- R10: Address 5 reads txLevel and address 6 reads rxLevel. Writes to read-only addresses (0, 2, 5 to 12) change nothing.
- R11: xferActive is 1 exactly when start-seen is set and stop-seen is clear.
- R12: regRdData is 0 when regRdEn is low, and reads of addresses 0 to 7 have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; clear reads act at the clock edge |
| regAddr | input | 4 | Register address |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data, combinational from address |
| evRxUnder | input | 1 | Receive underflow pulse |
| evRxOver | input | 1 | Receive overflow pulse |
| evTxOver | input | 1 | Transmit overflow pulse |
| evAbort | input | 1 | Transmit abort pulse |
| abortCause | input | 8 | Abort reasons sampled with evAbort |
| evStart | input | 1 | Start condition seen pulse |
| evStop | input | 1 | Stop condition seen pulse |
| txLevel | input | LVL_W | Transmit queue occupancy |
| rxLevel | input | LVL_W | Receive queue occupancy |
| irq | output | 1 | Interrupt request |
| txFlush | output | 1 | Holds the transmit queue flushed after an abort |
| xferActive | output | 1 | Transfer in progress indication |

## Verification
The assertions check on every cycle that irq agrees with a masked-status read, that sticky bits hold until their own clear, and that a clear without a simultaneous event empties the bit. They also check that an event arriving together with its clear survives, that an abort raises txFlush, that oversized threshold writes saturate, and that xferActive implies start without stop. The bench scenarios are needed to show the clear-read return values and the cause accumulation and reset. They also show the threshold comparisons against changing levels, that read-only writes are ignored, and the combined clear across all sticky bits. A reference model of the register window computes the expected values for these.

// File: rtl/intr_status_pkg.sv
package intr_status_pkg;
  localparam int ADDR_W = 4;
  localparam int STAT_W = 8;
  localparam int CAUSE_W = 8;

  localparam logic [ADDR_W-1:0] A_RAW    = 4'd0;
  localparam logic [ADDR_W-1:0] A_MASK   = 4'd1;
  localparam logic [ADDR_W-1:0] A_MASKED = 4'd2;
  localparam logic [ADDR_W-1:0] A_TXTHR  = 4'd3;
  localparam logic [ADDR_W-1:0] A_RXTHR  = 4'd4;
  localparam logic [ADDR_W-1:0] A_TXLVL  = 4'd5;
  localparam logic [ADDR_W-1:0] A_RXLVL  = 4'd6;
  localparam logic [ADDR_W-1:0] A_CAUSE  = 4'd7;
  localparam logic [ADDR_W-1:0] A_CLRALL = 4'd8;
  localparam logic [ADDR_W-1:0] A_CLRRXU = 4'd9;
  localparam logic [ADDR_W-1:0] A_CLRRXO = 4'd10;
  localparam logic [ADDR_W-1:0] A_CLRTXO = 4'd11;
  localparam logic [ADDR_W-1:0] A_CLRABT = 4'd12;

  // status bit positions
  localparam int B_RXU = 0;
  localparam int B_RXO = 1;
  localparam int B_RXF = 2;
  localparam int B_TXO = 3;
  localparam int B_TXE = 4;
  localparam int B_ABT = 5;
  localparam int B_STA = 6;
  localparam int B_STO = 7;

  localparam logic [STAT_W-1:0] STICKY_BITS = 8'b1110_1011;

  typedef struct packed {
    logic wrMask;
    logic wrTxThr;
    logic wrRxThr;
    logic clrRxUnder;
    logic clrRxOver;
    logic clrTxOver;
    logic clrAbort;
    logic clrAll;
  } ctrlStb_t;
endpackage

// File: rtl/intr_status_ctrl.sv
module intr_status_ctrl
  import intr_status_pkg::*;
(
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStb_t          stb
);
  always_comb begin
    stb            = '0;
    stb.wrMask     = regWrEn && (regAddr == A_MASK);
    stb.wrTxThr    = regWrEn && (regAddr == A_TXTHR);
    stb.wrRxThr    = regWrEn && (regAddr == A_RXTHR);
    stb.clrAll     = regRdEn && (regAddr == A_CLRALL);
    stb.clrRxUnder = regRdEn && (regAddr == A_CLRRXU);
    stb.clrRxOver  = regRdEn && (regAddr == A_CLRRXO);
    stb.clrTxOver  = regRdEn && (regAddr == A_CLRTXO);
    stb.clrAbort   = regRdEn && (regAddr == A_CLRABT);
  end
endmodule

// File: rtl/intr_status_dp.sv
module intr_status_dp
  import intr_status_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              evRxUnder,
  input  logic              evRxOver,
  input  logic              evTxOver,
  input  logic              evAbort,
  input  logic [CAUSE_W-1:0] abortCause,
  input  logic              evStart,
  input  logic              evStop,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  output logic              irq,
  output logic              txFlush,
  output logic              xferActive,
  output logic [STAT_W-1:0] rawStat,
  output logic [THR_W-1:0]  txThrQ
);
  localparam logic [DATA_W-1:0] THR_MAX = DATA_W'(DEPTH - 1);

  logic [STAT_W-1:0]  evVec, clrVec, lvlVec;
  logic [STAT_W-1:0]  maskQ;
  logic [THR_W-1:0]   rxThrQ;
  logic [CAUSE_W-1:0] causeQ;
  logic               abtClr;

  assign abtClr = stb.clrAbort | stb.clrAll;

  always_comb begin
    evVec         = '0;
    evVec[B_RXU]  = evRxUnder;
    evVec[B_RXO]  = evRxOver;
    evVec[B_TXO]  = evTxOver;
    evVec[B_ABT]  = evAbort;
    evVec[B_STA]  = evStart;
    evVec[B_STO]  = evStop;
    clrVec        = {STAT_W{stb.clrAll}};
    clrVec[B_RXU] = stb.clrRxUnder | stb.clrAll;
    clrVec[B_RXO] = stb.clrRxOver  | stb.clrAll;
    clrVec[B_TXO] = stb.clrTxOver  | stb.clrAll;
    clrVec[B_ABT] = abtClr;
    lvlVec        = '0;
    lvlVec[B_RXF] = rxLevel > LVL_W'(rxThrQ);
    lvlVec[B_TXE] = txLevel <= LVL_W'(txThrQ);
  end

  // one flop per sticky bit, a wire per level bit
  for (genvar i = 0; i < STAT_W; i++) begin : g_stat
    if (STICKY_BITS[i]) begin : g_sticky
      logic bitQ;
      always_ff @(posedge clk) begin
        if (!rstN) bitQ <= 1'b0;
        else       bitQ <= (bitQ & ~clrVec[i]) | evVec[i];
      end
      assign rawStat[i] = bitQ;
    end else begin : g_level
      assign rawStat[i] = lvlVec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ  <= '0;
      txThrQ <= '0;
      rxThrQ <= '0;
      causeQ <= '0;
    end else begin
      if (stb.wrMask)  maskQ  <= regWrData[STAT_W-1:0];
      if (stb.wrTxThr) txThrQ <= (regWrData > THR_MAX) ? THR_W'(DEPTH - 1) : regWrData[THR_W-1:0];
      if (stb.wrRxThr) rxThrQ <= (regWrData > THR_MAX) ? THR_W'(DEPTH - 1) : regWrData[THR_W-1:0];
      if (evAbort)     causeQ <= (abtClr ? '0 : causeQ) | abortCause;
      else if (abtClr) causeQ <= '0;
    end
  end

  assign irq        = |(rawStat & maskQ);
  assign txFlush    = rawStat[B_ABT];
  assign xferActive = rawStat[B_STA] & ~rawStat[B_STO];

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      case (regAddr)
        A_RAW:    regRdData = DATA_W'(rawStat);
        A_MASK:   regRdData = DATA_W'(maskQ);
        A_MASKED: regRdData = DATA_W'(rawStat & maskQ);
        A_TXTHR:  regRdData = DATA_W'(txThrQ);
        A_RXTHR:  regRdData = DATA_W'(rxThrQ);
        A_TXLVL:  regRdData = DATA_W'(txLevel);
        A_RXLVL:  regRdData = DATA_W'(rxLevel);
        A_CAUSE:  regRdData = DATA_W'(causeQ);
        A_CLRALL: regRdData = DATA_W'(|(rawStat & STICKY_BITS));
        A_CLRRXU: regRdData = DATA_W'(rawStat[B_RXU]);
        A_CLRRXO: regRdData = DATA_W'(rawStat[B_RXO]);
        A_CLRTXO: regRdData = DATA_W'(rawStat[B_TXO]);
        A_CLRABT: regRdData = DATA_W'(rawStat[B_ABT]);
        default:  regRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/intr_status_unit.sv
module intr_status_unit
  import intr_status_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               evRxUnder,
  input  logic               evRxOver,
  input  logic               evTxOver,
  input  logic               evAbort,
  input  logic [CAUSE_W-1:0] abortCause,
  input  logic               evStart,
  input  logic               evStop,
  input  logic [LVL_W-1:0]   txLevel,
  input  logic [LVL_W-1:0]   rxLevel,
  output logic               irq,
  output logic               txFlush,
  output logic               xferActive
);
  ctrlStb_t          stb;
  logic [STAT_W-1:0] rawStat;
  logic [THR_W-1:0]  txThrQ;

  intr_status_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .stb     (stb)
  );

  intr_status_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .regRdEn    (regRdEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .evRxUnder  (evRxUnder),
    .evRxOver   (evRxOver),
    .evTxOver   (evTxOver),
    .evAbort    (evAbort),
    .abortCause (abortCause),
    .evStart    (evStart),
    .evStop     (evStop),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel),
    .irq        (irq),
    .txFlush    (txFlush),
    .xferActive (xferActive),
    .rawStat    (rawStat),
    .txThrQ     (txThrQ)
  );
endmodule

// File: rtl/intr_status_chk.sv
module intr_status_chk
  import intr_status_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  localparam int THR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              evRxUnder,
  input logic              evAbort,
  input logic              evStart,
  input logic              irq,
  input logic              txFlush,
  input logic              xferActive,
  input logic [STAT_W-1:0] rawStat,
  input logic [THR_W-1:0]  txThrQ
);
  logic rdRxu, rdAll;
  assign rdRxu = regRdEn && (regAddr == A_CLRRXU);
  assign rdAll = regRdEn && (regAddr == A_CLRALL);

  assert_irq_masked_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == A_MASKED) |-> (irq == (regRdData != '0)));

  assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rawStat[B_RXU] && !rdRxu && !rdAll) |=> rawStat[B_RXU]);

  assert_clear_one_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdRxu && !evRxUnder) |=> !rawStat[B_RXU]);

  assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdAll && !evStart) |=> !rawStat[B_STA]);

  assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    evRxUnder |=> rawStat[B_RXU]);

  assert_abort_flush_R7: assert property (@(posedge clk) disable iff (!rstN)
    evAbort |=> txFlush);

  assert_thr_clamp_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_TXTHR && regWrData > DATA_W'(DEPTH - 1))
      |=> (txThrQ == THR_W'(DEPTH - 1)));

  assert_xfer_active_R11: assert property (@(posedge clk) disable iff (!rstN)
    xferActive |-> (rawStat[B_STA] && !rawStat[B_STO]));
endmodule

bind intr_status_unit intr_status_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regRdEn    (regRdEn),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .regRdData  (regRdData),
  .evRxUnder  (evRxUnder),
  .evAbort    (evAbort),
  .evStart    (evStart),
  .irq        (irq),
  .txFlush    (txFlush),
  .xferActive (xferActive),
  .rawStat    (rawStat),
  .txThrQ     (txThrQ)
);

// File: tb/intr_status_unit_bench.sv
`timescale 1ns/1ps
module intr_status_unit_bench;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 16;
  localparam int LVL_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0, regRdEn = 1'b0;
  logic [3:0]        regAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic              evRxUnder = 0, evRxOver = 0, evTxOver = 0, evAbort = 0, evStart = 0, evStop = 0;
  logic [7:0]        abortCause = '0;
  logic [LVL_W-1:0]  txLevel = '0, rxLevel = '0;
  logic              irq, txFlush, xferActive;

  always #2.5 clk = ~clk;

  intr_status_unit #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_intr_status_unit (.*);

  int nChecks = 0;
  int nFails  = 0;

  // reference model
  logic [7:0] mSticky = '0;
  logic [7:0] mMask   = '0;
  int         mTxThr  = 0;
  int         mRxThr  = 0;
  logic [7:0] mCause  = '0;

  function automatic logic [7:0] expRaw();
    logic [7:0] r;
    r    = mSticky;
    r[2] = int'(rxLevel) > mRxThr;
    r[4] = int'(txLevel) <= mTxThr;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] expRead(logic [3:0] a);
    case (a)
      4'd0:  return DATA_W'(expRaw());
      4'd1:  return DATA_W'(mMask);
      4'd2:  return DATA_W'(expRaw() & mMask);
      4'd3:  return DATA_W'(mTxThr);
      4'd4:  return DATA_W'(mRxThr);
      4'd5:  return DATA_W'(txLevel);
      4'd6:  return DATA_W'(rxLevel);
      4'd7:  return DATA_W'(mCause);
      4'd8:  return DATA_W'(mSticky != 0);
      4'd9:  return DATA_W'(mSticky[0]);
      4'd10: return DATA_W'(mSticky[1]);
      4'd11: return DATA_W'(mSticky[3]);
      4'd12: return DATA_W'(mSticky[5]);
      default: return '0;
    endcase
  endfunction

  function automatic string tagOf(logic [3:0] a);
    case (a)
      4'd0: return "R2";
      4'd1, 4'd2: return "R3";
      4'd3, 4'd4: return "R8";
      4'd5, 4'd6: return "R10";
      4'd7: return "R7";
      4'd8: return "R5";
      4'd9, 4'd10, 4'd11, 4'd12: return "R4";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int clampThr(logic [DATA_W-1:0] v);
    return (int'(v) > DEPTH - 1) ? DEPTH - 1 : int'(v);
  endfunction

  // one bus cycle: drive at negedge, check before the edge, then advance the model
  task automatic doCycle(string tag, logic rd, logic wr, logic [3:0] a, logic [DATA_W-1:0] wd,
                         logic [5:0] ev, logic [7:0] cause, int tl, int rl);
    logic [7:0] evVec, clr;
    @(negedge clk);
    regRdEn = rd; regWrEn = wr; regAddr = a; regWrData = wd;
    {evStop, evStart, evAbort, evTxOver, evRxOver, evRxUnder} = ev;
    abortCause = cause;
    txLevel = LVL_W'(tl); rxLevel = LVL_W'(rl);
    #1;
    check(rd ? tag : "R12", regRdData, rd ? expRead(a) : '0);
    check("R3", DATA_W'(irq), DATA_W'((expRaw() & mMask) != 0));
    check("R7", DATA_W'(txFlush), DATA_W'(mSticky[5]));
    check("R11", DATA_W'(xferActive), DATA_W'(mSticky[6] & ~mSticky[7]));
    evVec = {ev[5], ev[4], ev[3], 1'b0, ev[2], 1'b0, ev[1], ev[0]};
    clr = '0;
    if (rd) begin
      case (a)
        4'd8:  clr = 8'hEB;
        4'd9:  clr = 8'h01;
        4'd10: clr = 8'h02;
        4'd11: clr = 8'h08;
        4'd12: clr = 8'h20;
        default: clr = '0;
      endcase
    end
    if (clr[5]) mCause = '0;
    if (ev[3])  mCause = mCause | cause;
    mSticky = (mSticky & ~clr) | evVec;
    if (wr && a == 4'd1) mMask  = wd[7:0];
    if (wr && a == 4'd3) mTxThr = clampThr(wd);
    if (wr && a == 4'd4) mRxThr = clampThr(wd);
  endtask

  task automatic rdReg(string tag, logic [3:0] a, int tl, int rl);
    doCycle(tag, 1'b1, 1'b0, a, '0, '0, '0, tl, rl);
  endtask

  task automatic wrReg(logic [3:0] a, logic [DATA_W-1:0] d, int tl, int rl);
    doCycle("R12", 1'b0, 1'b1, a, d, '0, '0, tl, rl);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [3:0] a;
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset state (txLevel 3 keeps transmit-low clear)
    rdReg("R1", 4'd0, 3, 0);
    rdReg("R1", 4'd1, 3, 0);
    rdReg("R1", 4'd3, 3, 0);
    rdReg("R1", 4'd4, 3, 0);
    rdReg("R1", 4'd7, 3, 0);
    check("R1", DATA_W'(irq), '0);

    // R8: clamp reveals depth
    wrReg(4'd3, 16'd40, 3, 0);
    rdReg("R8", 4'd3, 3, 0);
    check("R8", regRdData, 16'd15);
    wrReg(4'd4, 16'd7, 3, 0);
    rdReg("R8", 4'd4, 3, 0);

    // R9: level comparisons, not sticky
    rdReg("R9", 4'd0, 15, 8);
    check("R9", regRdData & 16'h14, 16'h14);
    rdReg("R9", 4'd0, 16, 7);
    check("R9", regRdData & 16'h14, 16'h00);

    // R6: event arriving with its clear survives
    doCycle("R4", 1'b0, 1'b0, 4'd0, '0, 6'b000010, '0, 16, 0);
    doCycle("R6", 1'b1, 1'b0, 4'd10, '0, 6'b000010, '0, 16, 0);
    rdReg("R6", 4'd0, 16, 0);
    check("R6", regRdData & 16'h02, 16'h02);
    rdReg("R4", 4'd10, 16, 0);
    rdReg("R4", 4'd10, 16, 0);

    // R10: write to read-only level address ignored
    wrReg(4'd5, 16'h00FF, 9, 4);
    rdReg("R10", 4'd5, 9, 4);
    rdReg("R10", 4'd0, 9, 4);

    // R7: abort cause accumulate and clear
    doCycle("R7", 1'b0, 1'b0, 4'd0, '0, 6'b001000, 8'h0A, 16, 0);
    doCycle("R7", 1'b0, 1'b0, 4'd0, '0, 6'b001000, 8'h41, 16, 0);
    rdReg("R7", 4'd7, 16, 0);
    check("R7", regRdData, 16'h4B);
    rdReg("R7", 4'd12, 16, 0);
    rdReg("R7", 4'd7, 16, 0);
    check("R7", DATA_W'(txFlush), '0);

    // R11: start then stop; R5 combined clear
    doCycle("R11", 1'b0, 1'b0, 4'd0, '0, 6'b010000, '0, 16, 0);
    doCycle("R11", 1'b0, 1'b0, 4'd0, '0, 6'b100000, '0, 16, 0);
    rdReg("R5", 4'd8, 16, 0);
    rdReg("R5", 4'd0, 16, 0);
    check("R5", regRdData, 16'h0);

    // R3: mask
    wrReg(4'd1, 16'h10, 0, 0);
    rdReg("R3", 4'd2, 0, 0);

    // constrained random
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] ev;
      int op;
      ev = '0;
      for (int k = 0; k < 6; k++) ev[k] = ($urandom_range(0, 9) == 0);
      op = $urandom_range(0, 9);
      a  = 4'($urandom_range(0, 15));
      if (op < 5)
        doCycle(tagOf(a), 1'b1, 1'b0, a, '0, ev, 8'($urandom), $urandom_range(0, DEPTH), $urandom_range(0, DEPTH));
      else if (op < 7)
        doCycle("R10", 1'b0, 1'b1, a, 16'($urandom_range(0, 40)), ev, 8'($urandom),
                $urandom_range(0, DEPTH), $urandom_range(0, DEPTH));
      else
        doCycle("R2", 1'b0, 1'b0, a, '0, ev, 8'($urandom), $urandom_range(0, DEPTH), $urandom_range(0, DEPTH));
    end
    summary();
  end
endmodule